// File: doc/BRIEF.md
# Windowed Average Power Monitor

This block measures the mean power of a stream of signed samples over a window whose length software sets. Each enabled clock cycle carries one sample. The block squares the sample and adds the square to a wide accumulator. A down counter, loaded from the period input, marks where each window ends. When a window closes, the accumulator is divided by the smallest power of two that is not below the window length. The result is scaled into a 20-bit code and moved into a holding register. A one-cycle valid strobe marks each update.

In complex mode the two sample inputs are treated as the in-phase and quadrature parts of one signal, so each accumulated term is the sum of both squares. In real mode only the in-phase input counts. The sample that arrives on the cycle that closes a window becomes the first term of the next window. Because of this, every window holds exactly the programmed number of samples and no sample falls between windows.

Top module: `sig_power_mon`

## Requirements
- R1: After reset, `result` is 0 and `result_valid` is 0.
- R2: Every window holds exactly P enabled samples, where P is the window length in force. `result_valid` is high for one cycle. That cycle directly follows the clock edge that consumes the first enabled sample after the P samples of a window. It stays low on all other cycles.
- R3: The published value is min(floor(floor(S / 2^ceil(log2 P)) / 64), 1048575), where S is the exact sum of the window's per-sample powers. The accumulator never wraps.
- R4: The sample consumed on the cycle that closes a window is the first term of the next window.
- R5: While `enable` is 0, samples are ignored, the window position holds and `result_valid` stays 0.
- R6: With `complex_mode` = 1, the per-sample power is i*i + q*q. With `complex_mode` = 0 it is i*i, and `sample_q` has no effect.
- R7: A `period` value of 0 behaves as a window of one sample.
- R8: `period` is sampled only when a window starts. A change in the middle of a window takes effect from the next window.
- R9: `result` changes only in a cycle where `result_valid` is 1, and holds its value between updates.
- R10: A constant full-scale input of -8192 gives code 1048575. Larger sums saturate at that code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Monitor on; one sample consumed per cycle while high |
| complex_mode | input | 1 | 1: power is i*i+q*q; 0: power is i*i |
| period | input | 24 | Window length in samples (0 treated as 1) |
| sample_i | input | 14 | In-phase sample, two's complement |
| sample_q | input | 14 | Quadrature sample, two's complement |
| result | output | 20 | Holding register with the normalized mean power |
| result_valid | output | 1 | One-cycle pulse when `result` updates |

## Verification
Closing one window and opening the next always happen in the same cycle. On that edge the holding register takes the old sum, while the accumulator is reloaded with the power of the incoming sample and the counter with a fresh period. The bench provokes this with windows of distinct sample values. It judges the result by checking that the second published value contains the boundary sample and nothing from the first window. It also changes `period` in the middle of a window and uses period 1 and 0, where every cycle is a boundary. The expected results come from sums that the bench forms itself.

// File: rtl/sigpow_pkg.sv
// Shared helpers for the windowed power monitor.
// Assumes window lengths fit in 32 bits.
package sigpow_pkg;

    // Smallest s with 2^s >= value; value 0 or 1 gives 0.
    function automatic int unsigned ceil_log2(input logic [31:0] value);
        int unsigned r;
        r = 0;
        for (int b = 0; b < 32; b++) begin
            if ((64'(1) << b) < 64'(value)) begin
                r = b + 1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sigpow_term.sv
// Per-sample power term: squares each channel and adds the quadrature
// square only in complex mode. Purely combinational.
// Assumes two's complement samples of SAMPLE_W bits.
module sigpow_term #(
    parameter int SAMPLE_W = 14,
    localparam int TERM_W  = 2 * SAMPLE_W
) (
    input  logic                       complex_mode,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [SAMPLE_W-1:0] sample_q,
    output logic        [TERM_W-1:0]   term
);
    localparam int SQ_W = 2 * SAMPLE_W - 1;

    logic signed [SAMPLE_W-1:0] chan [2];
    logic        [SQ_W-1:0]     sq   [2];

    assign chan[0] = sample_i;
    assign chan[1] = sample_q;

    // One squarer per channel.
    for (genvar ch = 0; ch < 2; ch++) begin : g_sq
        logic signed [2*SAMPLE_W-1:0] prod;
        // Signed square is never negative, so its top bit is unused.
        always_comb prod = chan[ch] * chan[ch];
        assign sq[ch] = prod[SQ_W-1:0];
        // R6: a square is never negative.
        always_comb begin
            p_square_sign_r6: assert (!prod[2*SAMPLE_W-1]);
        end
    end

    // Combine channels according to the mode.
    always_comb begin
        term = TERM_W'(sq[0]);
        if (complex_mode) begin
            term = TERM_W'(sq[0]) + TERM_W'(sq[1]);
        end
    end
endmodule

// File: rtl/sigpow_window.sv
// Window timer: a down counter loaded with the period at each window
// start. A count of one marks the last slot; the next enabled sample
// closes the window and opens the following one.
// Assumes period 0 means a one-sample window.
module sigpow_window #(
    parameter int PERIOD_W = 24,
    localparam int SHIFT_W = $clog2(PERIOD_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    output logic                win_start,
    output logic                win_publish,
    output logic [SHIFT_W-1:0]  shift_amt
);
    import sigpow_pkg::*;

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] per_q;
    logic [PERIOD_W-1:0] per_eff;
    logic [SHIFT_W-1:0]  shift_q;

    // Zero period is promoted to one.
    always_comb per_eff = (period == '0) ? PERIOD_W'(1) : period;

    // Window boundary decode: count 0 (idle after reset) or 1 (last slot).
    always_comb begin
        win_start   = enable && (cnt_q <= PERIOD_W'(1));
        win_publish = enable && (cnt_q == PERIOD_W'(1));
    end

    assign shift_amt = shift_q;

    // Counter, latched period and normalising shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            per_q   <= '0;
            shift_q <= '0;
        end else if (win_start) begin
            cnt_q   <= per_eff;
            per_q   <= per_eff;
            shift_q <= SHIFT_W'(ceil_log2(32'(per_eff)));
        end else if (enable) begin
            cnt_q   <= cnt_q - PERIOD_W'(1);
        end
    end

    // R2: the count never exceeds the latched window length.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q);
    // R8: a new window loads the period present at its start.
    p_load_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> (cnt_q == $past(per_eff)) && (per_q == $past(per_eff)));
    // R5: a disabled cycle leaves the window position untouched.
    p_hold_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(cnt_q) && $stable(shift_q));
endmodule

// File: rtl/sigpow_accum.sv
// Accumulator and holding register. Adds each enabled term, reloads
// with the current term at a window start, and at a window close
// normalises the old sum into the holding register and pulses valid.
// Assumes ACC_W covers 2^PERIOD_W full-scale complex terms.
module sigpow_accum #(
    parameter int SAMPLE_W = 14,
    parameter int PERIOD_W = 24,
    parameter int RESULT_W = 20,
    localparam int TERM_W  = 2 * SAMPLE_W,
    localparam int ACC_W   = TERM_W + PERIOD_W + 1,
    localparam int SHIFT_W = $clog2(PERIOD_W + 1),
    localparam int DROP    = 2 * SAMPLE_W - 2 - RESULT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                win_start,
    input  logic                win_publish,
    input  logic [SHIFT_W-1:0]  shift_amt,
    input  logic [TERM_W-1:0]   term,
    output logic [RESULT_W-1:0] result,
    output logic                result_valid
);
    localparam logic [ACC_W-1:0] CODE_MAX = ACC_W'({RESULT_W{1'b1}});

    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    mean;
    logic [ACC_W-1:0]    scaled;
    logic [RESULT_W-1:0] code;
    logic [RESULT_W-1:0] hold_q;
    logic                valid_q;

    // Normalise: divide by 2^shift, drop scale bits, saturate.
    always_comb begin
        mean   = acc_q >> shift_amt;
        scaled = mean >> DROP;
        code   = (scaled > CODE_MAX) ? {RESULT_W{1'b1}} : scaled[RESULT_W-1:0];
    end

    // Running sum; reloads with the incoming term at a window start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (win_start) begin
            acc_q <= ACC_W'(term);
        end else if (enable) begin
            acc_q <= acc_q + ACC_W'(term);
        end
    end

    // Holding register and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= win_publish;
            if (win_publish) begin
                hold_q <= code;
            end
        end
    end

    assign result       = hold_q;
    assign result_valid = valid_q;

    // R3: accumulation inside a window never wraps.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !win_start) |=> acc_q >= $past(acc_q));
    // R5: a disabled cycle leaves the sum untouched.
    p_hold_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(acc_q));
    // R9: the held value moves only together with the strobe.
    p_stable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(hold_q));
    // R2: the strobe only follows an enabled cycle.
    p_valid_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(enable));
endmodule

// File: rtl/sig_power_mon.sv
// Windowed average power monitor, top level. Links the term generator,
// window timer and accumulator. One sample per enabled cycle.
// Assumes RESULT_W <= 2*SAMPLE_W-2 and PERIOD_W <= 32.
module sig_power_mon #(
    parameter int SAMPLE_W = 14,
    parameter int PERIOD_W = 24,
    parameter int RESULT_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                complex_mode,
    input  logic [PERIOD_W-1:0] period,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [SAMPLE_W-1:0] sample_q,
    output logic [RESULT_W-1:0] result,
    output logic                result_valid
);
    localparam int TERM_W  = 2 * SAMPLE_W;
    localparam int SHIFT_W = $clog2(PERIOD_W + 1);

    logic [TERM_W-1:0]  term;
    logic               win_start;
    logic               win_publish;
    logic [SHIFT_W-1:0] shift_amt;

    sigpow_term #(.SAMPLE_W(SAMPLE_W)) u_term (
        .complex_mode (complex_mode),
        .sample_i     ($signed(sample_i)),
        .sample_q     ($signed(sample_q)),
        .term         (term)
    );

    sigpow_window #(.PERIOD_W(PERIOD_W)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .period      (period),
        .win_start   (win_start),
        .win_publish (win_publish),
        .shift_amt   (shift_amt)
    );

    sigpow_accum #(
        .SAMPLE_W (SAMPLE_W),
        .PERIOD_W (PERIOD_W),
        .RESULT_W (RESULT_W)
    ) u_accum (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .win_start    (win_start),
        .win_publish  (win_publish),
        .shift_amt    (shift_amt),
        .term         (term),
        .result       (result),
        .result_valid (result_valid)
    );
endmodule

// File: tb/sig_power_mon_bench.sv
module sig_power_mon_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        complex_mode = 1'b0;
    logic [23:0] period = 24'd1;
    logic [13:0] sample_i = '0;
    logic [13:0] sample_q = '0;
    logic [19:0] result;
    logic        result_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sig_power_mon u_sig_power_mon (
        .clk(clk), .rst_n(rst_n), .enable(enable), .complex_mode(complex_mode),
        .period(period), .sample_i(sample_i), .sample_q(sample_q),
        .result(result), .result_valid(result_valid)
    );

    // Stimulus table: period, complex flag, i, q (constant over a window).
    localparam int NV = 9;
    localparam int V_PER [NV] = '{4, 4, 5, 1, 0, 16, 3, 7, 2};
    localparam int V_CPX [NV] = '{0, 1, 0, 0, 0, 1, 0, 1, 0};
    localparam int V_I   [NV] = '{100, 100, -300, 8191, -50, -8192, -8192, 1234, 0};
    localparam int V_Q   [NV] = '{0, -200, 7, 0, 0, -8192, 0, -4321, 5};

    function automatic int clog2f(input longint p);
        int s = 0;
        while ((64'(1) << s) < p) s++;
        return s;
    endfunction

    function automatic longint expect_code(input longint sum, input longint p);
        longint pe = (p == 0) ? 1 : p;
        longint v = (sum >> clog2f(pe)) >> 6;
        return (v > 1048575) ? 1048575 : v;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic en, input int i, input int q);
        @(negedge clk);
        enable = en;
        sample_i = 14'(i);
        sample_q = 14'(q);
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        enable = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        check("R1 result", result, 0);
        check("R1 valid", result_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint t, pe;
        // Table walk: R2, R3, R6, R7, R10.
        for (int k = 0; k < NV; k++) begin
            do_reset();
            period = 24'(V_PER[k]);
            complex_mode = V_CPX[k][0];
            pe = (V_PER[k] == 0) ? 1 : V_PER[k];
            t = longint'(V_I[k]) * V_I[k] + (V_CPX[k] != 0 ? longint'(V_Q[k]) * V_Q[k] : 0);
            for (int n = 0; n < pe; n++) cyc(1'b1, V_I[k], V_Q[k]);
            check("R2/R7 no early valid", result_valid, 0);
            cyc(1'b1, V_I[k], V_Q[k]);
            check("R2/R7 valid at close", result_valid, 1);
            check("R3/R6/R10 code", result, expect_code(pe * t, V_PER[k]));
        end

        // R4 and R9: boundary sample opens the next window; hold stays put.
        do_reset();
        period = 24'd3;
        complex_mode = 1'b0;
        cyc(1'b1, 4000, 0);
        cyc(1'b1, -3000, 0);
        cyc(1'b1, 2000, 0);
        cyc(1'b1, 1000, 0);
        check("R4 first valid", result_valid, 1);
        check("R4 first code", result, expect_code(29000000, 3));
        cyc(1'b1, -500, 0);
        check("R9 valid low", result_valid, 0);
        check("R9 hold stable", result, expect_code(29000000, 3));
        cyc(1'b1, 7000, 0);
        check("R9 hold stable 2", result, expect_code(29000000, 3));
        cyc(1'b1, 5, 0);
        check("R4 second valid", result_valid, 1);
        check("R4 boundary sample kept", result, expect_code(1000000 + 250000 + 49000000, 3));

        // R5: disabled cycles ignore samples and freeze the window.
        do_reset();
        period = 24'd4;
        cyc(1'b1, 300, 0);
        cyc(1'b1, 300, 0);
        for (int n = 0; n < 3; n++) begin
            cyc(1'b0, 8000, 0);
            check("R5 no valid while off", result_valid, 0);
        end
        cyc(1'b1, 300, 0);
        cyc(1'b1, 300, 0);
        check("R5 window not closed early", result_valid, 0);
        cyc(1'b1, 10, 0);
        check("R5 valid", result_valid, 1);
        check("R5 code excludes ignored samples", result, expect_code(4 * 90000, 4));

        // R8: period change mid-window applies from the next window.
        do_reset();
        period = 24'd2;
        cyc(1'b1, 100, 0);
        period = 24'd4;
        cyc(1'b1, 100, 0);
        cyc(1'b1, 200, 0);
        check("R8 old length used", result_valid, 1);
        check("R8 old window code", result, expect_code(20000, 2));
        cyc(1'b1, 200, 0);
        cyc(1'b1, 200, 0);
        cyc(1'b1, 200, 0);
        check("R8 new length no early valid", result_valid, 0);
        cyc(1'b1, 50, 0);
        check("R8 new length valid", result_valid, 1);
        check("R8 new window code", result, expect_code(160000, 4));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule